// File: doc/BRIEF.md
# Vector Source Operand Fetch

This block assembles the three four-component source operands of one vector-program instruction. Each source descriptor names a register type (temporary, input or constant), a temporary identifier, a per-lane component selection, and a negate flag. A separate absolute-value flag is provided for each source. The block sends read addresses to three temporary-file ports, one input-file port and one constant-file port. These files return their data in the same cycle. For every result lane the block picks a component, then applies absolute value and negate by working on the IEEE single-precision sign bit. It registers the three result vectors.

An instruction may read at most one input register and at most one constant, so all sources of those two types share one port each. The constant address is either the instruction's constant field or that field plus one component of one of two address registers. The address-register select bit and a two-bit component code choose that component. A relative address that falls outside the constant file wraps, and an error flag is raised for that result.

Top module: `vsrc_fetch`

## Requirements
- R1: A source of type temporary (descriptor bits 1:0 = 1) reads the temporary port for its own source index at the identifier held in descriptor bits 5:2. Result lanes X, Y, Z and W take the component selected by descriptor bits 13:12, 11:10, 9:8 and 7:6. Code 0 means X, 1 Y, 2 Z and 3 W. Component X lies in vector bits 31:0 and W in bits 127:96.
- R2: A source of type input (code 2) takes the vector returned on the single input port, whose address equals the input field. Every input-type source of the instruction sees that same vector.
- R3: When the constant-index flag is low, the constant read address equals the constant field. A source of type constant (code 3) takes the vector returned on the single constant port.
- R4: When the constant-index flag is high, the constant address equals the constant field plus a two's-complement component of an address register, taken modulo the constant-file size. Register select 0 or 1 chooses the register, and the two-bit code chooses its component. Component c of register r occupies address-register bus bits [(4r+c)*AREG_W +: AREG_W].
- R5: addr_err is high on a result cycle exactly when an indexed constant address fell below 0 or above the last entry. It is low otherwise, and always low when the index flag is low.
- R6: Descriptor bit 14 (negate) inverts bit 31 of every lane and leaves all other bits unchanged.
- R7: The absolute-value flag of a source clears bit 31 of every lane before negate, so abs together with negate yields bit 31 set.
- R8: A source of type 0 yields an all-zero vector whatever its negate, swizzle or abs settings.
- R9: An instruction presented with valid_in high is reflected on op0..op2, addr_err and op_valid one clock later. When valid_in is low, op_valid and addr_err go low on the next clock and the operand outputs hold their values.
- R10: After synchronous reset, op_valid, addr_err and all operand outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | An instruction's source fields are present |
| src0_desc | input | 15 | Source 0 descriptor |
| src1_desc | input | 15 | Source 1 descriptor |
| src2_desc | input | 15 | Source 2 descriptor |
| abs_en | input | 3 | Absolute-value flag per source, bit s for source s |
| const_field | input | CONST_AW (8) | Constant index field |
| input_field | input | IN_AW (4) | Input register index field |
| const_indexed | input | 1 | Use address-register relative constant addressing |
| areg_sel | input | 1 | Chooses address register 1 instead of 0 |
| areg_swz | input | 2 | Chooses the address-register component |
| areg_file | input | 8*AREG_W (80) | Both address registers, four signed components each |
| temp_raddr | output | 12 | Temporary read address per source, 4 bits each |
| temp_rdata | input | 12*DATA_W (384) | Temporary read data per source port |
| input_raddr | output | IN_AW (4) | Shared input read address |
| input_rdata | input | 4*DATA_W (128) | Shared input read data |
| const_raddr | output | CONST_AW (8) | Shared constant read address |
| const_rdata | input | 4*DATA_W (128) | Shared constant read data |
| op_valid | output | 1 | Operand outputs carry a new result |
| addr_err | output | 1 | Relative constant address wrapped on this result |
| op0 | output | 4*DATA_W (128) | Source 0 operand |
| op1 | output | 4*DATA_W (128) | Source 1 operand |
| op2 | output | 4*DATA_W (128) | Source 2 operand |

## Verification
A relative constant address that wraps can coincide with the sign handling on the constant it fetches. The wrap changes which vector arrives, and abs and negate then modify that wrapped vector's sign bits in the same result cycle. Directed cases pair an out-of-range offset (below zero and beyond the top entry) with abs and negate on a constant source. The bench judges them by recomputing the wrapped address and the expected sign bits on its own, then comparing the operand and addr_err together. Random instructions also draw small address-register offsets around the file edges, so this overlap recurs with random swizzles and register types.

// File: rtl/vsf_pkg.sv
package vsf_pkg;

    localparam int SRC_W   = 15;
    localparam int NSRC    = 3;
    localparam int NCOMP   = 4;
    localparam int TID_W   = 4;
    localparam int NAREG   = 2;

    typedef enum logic [1:0] {
        RT_NONE  = 2'd0,
        RT_TEMP  = 2'd1,
        RT_INPUT = 2'd2,
        RT_CONST = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic                  neg;
        logic [0:NCOMP-1][1:0] swz;
        logic [TID_W-1:0]      tid;
        reg_kind_e             kind;
    } src_desc_t;

    function automatic logic [31:0] sign_fix(input logic [31:0] w,
                                             input logic make_abs,
                                             input logic negate);
        logic s;
        s = (w[31] & ~make_abs) ^ negate;
        return {s, w[30:0]};
    endfunction

endpackage

// File: rtl/vsf_const_addr.sv
module vsf_const_addr
    import vsf_pkg::*;
#(
    parameter int CONST_AW = 8,
    parameter int AREG_W   = 10
) (
    input  logic [CONST_AW-1:0]              const_field,
    input  logic                             indexed,
    input  logic                             sel,
    input  logic [1:0]                       swz,
    input  logic [NAREG*NCOMP*AREG_W-1:0]    areg_file,
    output logic [CONST_AW-1:0]              addr,
    output logic                             range_err
);
    localparam int SUM_W = ((AREG_W > CONST_AW) ? AREG_W : CONST_AW) + 2;

    logic [2:0]        slot;
    logic [AREG_W-1:0] ofs;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        slot = {sel, swz};
        ofs  = areg_file[int'(slot)*AREG_W +: AREG_W];
        sum  = {{(SUM_W-CONST_AW){1'b0}}, const_field}
             + {{(SUM_W-AREG_W){ofs[AREG_W-1]}}, ofs};
        if (indexed) begin
            addr      = sum[CONST_AW-1:0];
            range_err = |sum[SUM_W-1:CONST_AW];
        end else begin
            addr      = const_field;
            range_err = 1'b0;
        end
    end
endmodule

// File: rtl/vsf_operand.sv
module vsf_operand
    import vsf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [SRC_W-1:0]          desc_bits,
    input  logic                      abs_en,
    input  logic [NCOMP*DATA_W-1:0]   temp_data,
    input  logic [NCOMP*DATA_W-1:0]   in_data,
    input  logic [NCOMP*DATA_W-1:0]   const_data,
    output logic [NCOMP*DATA_W-1:0]   result
);
    src_desc_t                  d;
    logic [NCOMP*DATA_W-1:0]    raw;

    assign d = src_desc_t'(desc_bits);

    always_comb begin
        case (d.kind)
            RT_TEMP:  raw = temp_data;
            RT_INPUT: raw = in_data;
            RT_CONST: raw = const_data;
            default:  raw = '0;
        endcase
    end

    for (genvar c = 0; c < NCOMP; c++) begin : g_lane
        logic [DATA_W-1:0] pick;
        logic              sgn;
        assign pick = raw[int'(d.swz[c])*DATA_W +: DATA_W];
        assign sgn  = (pick[DATA_W-1] & ~abs_en) ^ d.neg;
        assign result[c*DATA_W +: DATA_W] =
            (d.kind == RT_NONE) ? '0 : {sgn, pick[DATA_W-2:0]};
    end
endmodule

// File: rtl/vsrc_fetch.sv
module vsrc_fetch
    import vsf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CONST_AW = 8,
    parameter int IN_AW    = 4,
    parameter int AREG_W   = 10
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              valid_in,
    input  logic [SRC_W-1:0]                  src0_desc,
    input  logic [SRC_W-1:0]                  src1_desc,
    input  logic [SRC_W-1:0]                  src2_desc,
    input  logic [NSRC-1:0]                   abs_en,
    input  logic [CONST_AW-1:0]               const_field,
    input  logic [IN_AW-1:0]                  input_field,
    input  logic                              const_indexed,
    input  logic                              areg_sel,
    input  logic [1:0]                        areg_swz,
    input  logic [NAREG*NCOMP*AREG_W-1:0]     areg_file,
    output logic [NSRC*TID_W-1:0]             temp_raddr,
    input  logic [NSRC*NCOMP*DATA_W-1:0]      temp_rdata,
    output logic [IN_AW-1:0]                  input_raddr,
    input  logic [NCOMP*DATA_W-1:0]           input_rdata,
    output logic [CONST_AW-1:0]               const_raddr,
    input  logic [NCOMP*DATA_W-1:0]           const_rdata,
    output logic                              op_valid,
    output logic                              addr_err,
    output logic [NCOMP*DATA_W-1:0]           op0,
    output logic [NCOMP*DATA_W-1:0]           op1,
    output logic [NCOMP*DATA_W-1:0]           op2
);
    localparam int VEC_W = NCOMP * DATA_W;

    logic [NSRC-1:0][SRC_W-1:0] desc;
    logic [NSRC-1:0][VEC_W-1:0] op_d;
    logic [NSRC-1:0][VEC_W-1:0] op_q;
    logic                       range_err;

    assign desc[0] = src0_desc;
    assign desc[1] = src1_desc;
    assign desc[2] = src2_desc;

    assign input_raddr = input_field;

    vsf_const_addr #(
        .CONST_AW (CONST_AW),
        .AREG_W   (AREG_W)
    ) u_caddr (
        .const_field (const_field),
        .indexed     (const_indexed),
        .sel         (areg_sel),
        .swz         (areg_swz),
        .areg_file   (areg_file),
        .addr        (const_raddr),
        .range_err   (range_err)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        src_desc_t ds;
        assign ds = src_desc_t'(desc[s]);
        assign temp_raddr[s*TID_W +: TID_W] = ds.tid;

        vsf_operand #(
            .DATA_W (DATA_W)
        ) u_opnd (
            .desc_bits  (desc[s]),
            .abs_en     (abs_en[s]),
            .temp_data  (temp_rdata[s*VEC_W +: VEC_W]),
            .in_data    (input_rdata),
            .const_data (const_rdata),
            .result     (op_d[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_valid <= 1'b0;
            addr_err <= 1'b0;
            op_q     <= '0;
        end else begin
            op_valid <= valid_in;
            addr_err <= valid_in & range_err;
            if (valid_in) begin
                op_q <= op_d;
            end
        end
    end

    assign op0 = op_q[0];
    assign op1 = op_q[1];
    assign op2 = op_q[2];
endmodule

// File: rtl/vsf_checker.sv
module vsf_checker
    import vsf_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CONST_AW = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      valid_in,
    input logic [SRC_W-1:0]          src0_desc,
    input logic [CONST_AW-1:0]       const_field,
    input logic                      const_indexed,
    input logic [CONST_AW-1:0]       const_raddr,
    input logic                      op_valid,
    input logic                      addr_err,
    input logic [NCOMP*DATA_W-1:0]   op0,
    input logic [NCOMP*DATA_W-1:0]   op1,
    input logic [NCOMP*DATA_W-1:0]   op2
);
    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> op_valid);

    a_r9_idle_drops: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !op_valid);

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(op0) && $stable(op1) && $stable(op2)));

    a_r5_err_needs_valid: assert property (@(posedge clk) disable iff (rst)
        addr_err |-> op_valid);

    a_r5_direct_no_err: assert property (@(posedge clk) disable iff (rst)
        (valid_in && !const_indexed) |=> !addr_err);

    a_r3_direct_addr: assert property (@(posedge clk) disable iff (rst)
        !const_indexed |-> (const_raddr == const_field));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_in && src0_desc[1:0] == 2'd0) |=> (op0 == '0));
endmodule

bind vsrc_fetch vsf_checker #(
    .DATA_W   (DATA_W),
    .CONST_AW (CONST_AW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .valid_in      (valid_in),
    .src0_desc     (src0_desc),
    .const_field   (const_field),
    .const_indexed (const_indexed),
    .const_raddr   (const_raddr),
    .op_valid      (op_valid),
    .addr_err      (addr_err),
    .op0           (op0),
    .op1           (op1),
    .op2           (op2)
);

// File: tb/vsrc_fetch_test.sv
`timescale 1ns/1ps
module vsrc_fetch_test;
    logic          clk = 1'b0;
    logic          rst;
    logic          valid_in;
    logic [14:0]   src0_desc, src1_desc, src2_desc;
    logic [2:0]    abs_en;
    logic [7:0]    const_field;
    logic [3:0]    input_field;
    logic          const_indexed;
    logic          areg_sel;
    logic [1:0]    areg_swz;
    logic [79:0]   areg_file;
    logic [11:0]   temp_raddr;
    logic [383:0]  temp_rdata;
    logic [3:0]    input_raddr;
    logic [127:0]  input_rdata;
    logic [7:0]    const_raddr;
    logic [127:0]  const_rdata;
    logic          op_valid;
    logic          addr_err;
    logic [127:0]  op0, op1, op2;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    vsrc_fetch uut (.*);

    function automatic logic [127:0] vecof(input int kind, input int idx);
        logic [127:0] v;
        for (int c = 0; c < 4; c++) begin
            v[c*32 +: 32] = 32'(kind) * 32'h01000193 + 32'(idx) * 32'h9E3779B1
                          + 32'(c) * 32'h7F4A7C15 + 32'h5BD1E995 * 32'(idx * idx + c + kind);
        end
        return v;
    endfunction

    always_comb begin
        for (int s = 0; s < 3; s++)
            temp_rdata[s*128 +: 128] = vecof(1, int'(temp_raddr[s*4 +: 4]));
        input_rdata = vecof(2, int'(input_raddr));
        const_rdata = vecof(3, int'(const_raddr));
    end

    function automatic logic [14:0] mkdesc(input logic neg, input int x, input int y,
                                           input int z, input int w, input int tid,
                                           input int kind);
        return {neg, 2'(x), 2'(y), 2'(z), 2'(w), 4'(tid), 2'(kind)};
    endfunction

    function automatic logic [9:0] aval(input int v);
        return 10'(v);
    endfunction

    function automatic logic [127:0] expop(input logic [14:0] d, input logic ab, input int caddr);
        logic [127:0] raw, r;
        logic [31:0]  w;
        int           sel;
        case (d[1:0])
            2'd1:    raw = vecof(1, int'(d[5:2]));
            2'd2:    raw = vecof(2, int'(input_field));
            2'd3:    raw = vecof(3, caddr);
            default: return '0;
        endcase
        for (int c = 0; c < 4; c++) begin
            sel = int'(d[13-2*c -: 2]);
            w   = raw[sel*32 +: 32];
            if (ab)    w[31] = 1'b0;
            if (d[14]) w[31] = ~w[31];
            r[c*32 +: 32] = w;
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    // Drives nothing; inputs are set by the caller after a negedge.
    task automatic step(input string tag);
        int           a;
        logic         e_err;
        int           e_addr;
        logic [9:0]   ov;
        logic [127:0] e0, e1, e2;
        ov = areg_file[int'({areg_sel, areg_swz})*10 +: 10];
        if (const_indexed) begin
            a      = int'(const_field) + int'($signed(ov));
            e_err  = (a < 0) || (a > 255);
            e_addr = a & 255;
        end else begin
            e_err  = 1'b0;
            e_addr = int'(const_field);
        end
        e0 = expop(src0_desc, abs_en[0], e_addr);
        e1 = expop(src1_desc, abs_en[1], e_addr);
        e2 = expop(src2_desc, abs_en[2], e_addr);
        #1;
        chk({tag, " R3/R4 const address"}, 128'(const_raddr), 128'(e_addr));
        @(posedge clk);
        #1;
        chk({tag, " R9 op_valid"}, 128'(op_valid), 128'(1));
        chk({tag, " R5 addr_err"}, 128'(addr_err), 128'(e_err));
        chk({tag, " R1 op0"}, op0, e0);
        chk({tag, " R1 op1"}, op1, e1);
        chk({tag, " R1 op2"}, op2, e2);
    endtask

    task automatic set_areg(input int r, input int c, input int v);
        areg_file[(r*4 + c)*10 +: 10] = aval(v);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] held0;
        void'($urandom(32'd2024));
        rst = 1'b1; valid_in = 1'b0;
        src0_desc = '0; src1_desc = '0; src2_desc = '0; abs_en = '0;
        const_field = '0; input_field = '0; const_indexed = 1'b0;
        areg_sel = 1'b0; areg_swz = '0; areg_file = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R10 op_valid reset", 128'(op_valid), 128'(0));
        chk("R10 addr_err reset", 128'(addr_err), 128'(0));
        chk("R10 op0 reset", op0, '0);
        chk("R10 op1 reset", op1, '0);
        chk("R10 op2 reset", op2, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1: reversed and repeated swizzles on temporaries
        @(negedge clk);
        valid_in  = 1'b1;
        src0_desc = mkdesc(0, 3, 2, 1, 0, 5, 1);
        src1_desc = mkdesc(0, 1, 1, 1, 1, 9, 1);
        src2_desc = mkdesc(0, 0, 1, 2, 3, 15, 1);
        step("R1 swizzle");

        // R8: reserved type with negate and abs set; R2: shared input port
        @(negedge clk);
        src0_desc = mkdesc(1, 2, 3, 0, 1, 7, 0);
        abs_en    = 3'b001;
        input_field = 4'd11;
        src1_desc = mkdesc(0, 0, 1, 2, 3, 0, 2);
        src2_desc = mkdesc(1, 3, 3, 0, 0, 0, 2);
        step("R8 R2 reserved+input");

        // R6 R7: abs alone, negate alone, abs with negate on constants
        @(negedge clk);
        const_field = 8'd77;
        src0_desc = mkdesc(1, 0, 1, 2, 3, 0, 3);
        src1_desc = mkdesc(1, 0, 1, 2, 3, 0, 3);
        src2_desc = mkdesc(0, 0, 1, 2, 3, 0, 3);
        abs_en    = 3'b110;
        step("R6 R7 sign");
        chk("R7 abs+neg sign bit", 128'(op1[31]), 128'(1));

        // R4: register 1, component Z
        @(negedge clk);
        set_areg(1, 2, 5); set_areg(0, 2, 100); set_areg(1, 0, -3);
        const_indexed = 1'b1; areg_sel = 1'b1; areg_swz = 2'd2;
        const_field = 8'd10; abs_en = 3'b000;
        step("R4 select reg1.z");

        // R5 with R7: wrap below zero, abs+neg on the fetched constant
        @(negedge clk);
        set_areg(0, 3, -5);
        areg_sel = 1'b0; areg_swz = 2'd3; const_field = 8'd3;
        abs_en = 3'b111;
        src0_desc = mkdesc(1, 3, 2, 1, 0, 0, 3);
        step("R5 wrap low");

        // R5: wrap beyond top entry
        @(negedge clk);
        set_areg(1, 1, 10);
        areg_sel = 1'b1; areg_swz = 2'd1; const_field = 8'd250;
        step("R5 wrap high");

        // R5: exactly the last entry, no error
        @(negedge clk);
        set_areg(1, 1, 5);
        step("R5 top edge");

        // R9: idle cycle holds outputs
        held0 = op0;
        @(negedge clk);
        valid_in = 1'b0;
        src0_desc = mkdesc(0, 1, 2, 3, 0, 3, 1);
        const_field = 8'd1;
        @(posedge clk); #1;
        chk("R9 idle op_valid", 128'(op_valid), 128'(0));
        chk("R9 idle addr_err", 128'(addr_err), 128'(0));
        chk("R9 idle hold op0", op0, held0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            valid_in      = 1'b1;
            src0_desc     = 15'($urandom);
            src1_desc     = 15'($urandom);
            src2_desc     = 15'($urandom);
            abs_en        = 3'($urandom);
            input_field   = 4'($urandom);
            const_indexed = 1'($urandom);
            areg_sel      = 1'($urandom);
            areg_swz      = 2'($urandom);
            const_field   = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(0, 8))
                          : ($urandom_range(0, 2) == 0) ? 8'($urandom_range(247, 255))
                          : 8'($urandom);
            for (int k = 0; k < 8; k++)
                areg_file[k*10 +: 10] = aval(int'($urandom_range(0, 40)) - 20);
            step("R1 R4 R6 R7 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule